// File: doc/BRIEF.md
# Write Allocate Decision Unit

This unit sits beside the L1 data cache and decides, for every write that misses the cache, whether the line should be brought in. The decision is made in the same cycle as the write request. It is a pure yes/no flag that the cache controller samples together with the request.

The decision works in two stages. First, three global gates must all be open: the global cache-off bit, the per-access page no-cache signal and the cache-inhibit test bit. Then at least one qualifier must hold. There are three qualifiers:
- the write falls in the same 4 KB page as the most recent read-miss line fill;
- the write hits a sector that is already present;
- the write lies below a programmable address limit and outside two fixed excluded windows.

The unit watches read-miss fills so that it can keep the page of the most recent fill. The request and fill inputs are plain per-cycle strobes, not valid/ready streams. The flag is combinational and the cache controller never stalls, so there is no back-pressure.

Top module: `wa_alloc_decide`

## Requirements
- R1: When `cache_off` is 1, `alloc_o` is 0 whatever the qualifiers are.
- R2: When `page_nocache` is 1, `alloc_o` is 0 whatever the qualifiers are.
- R3: When `cache_inhibit` is 1, `alloc_o` is 0 whatever the qualifiers are.
- R4: A cycle with `fill_valid` 1 loads `fill_addr[31:12]` into the last-fill page register on that clock edge. From the next cycle, a write with `wr_addr[31:12]` equal to the stored page qualifies. A write to any other page does not qualify through this path.
- R5: A write in the same cycle as a fill is judged against the page register's previous contents, not against the new fill.
- R6: A write with `sector_hit` 1 qualifies for allocation.
- R7: With `lim_en` 1 and `lim_val` not 0, a write with address below `lim_val` × 4 MB qualifies, subject to R8 and R9. With `lim_en` 0 or `lim_val` 0, the limit path never qualifies.
- R8: Addresses 000A_0000h to 000F_FFFFh never qualify through the limit path.
- R9: Addresses 00F0_0000h to 00FF_FFFFh qualify through the limit path only when `upper_en` is 1.
- R10: `alloc_o` is 0 in every cycle where `wr_req` is 0.
- R11: After reset the page register is marked empty, so no write qualifies through the page path until the first fill. This includes writes to page 0.
- R12: A write with all gates open but no qualifier gives `alloc_o` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | A write miss is being judged this cycle |
| wr_addr | input | 32 | Byte address of the write |
| sector_hit | input | 1 | The write hits a sector that is already present |
| cache_off | input | 1 | Global cache-off control bit |
| page_nocache | input | 1 | Page-level no-cache signal for this access |
| cache_inhibit | input | 1 | Cache-inhibit test bit |
| lim_en | input | 1 | Enables the limit-based path |
| lim_val | input | 7 | Limit in 4 MB units; 0 turns the path off |
| upper_en | input | 1 | Allows the 15–16 MB window on the limit path |
| fill_valid | input | 1 | A read-miss line fill is reported this cycle |
| fill_addr | input | 32 | Address of the reported fill |
| alloc_o | output | 1 | Perform write allocate |

## Verification
The bench targets the following corner cases:
- A write to page 0 straight after reset. A design that treats the cleared page register as valid would allocate here.
- A write in the same cycle as a fill to its page. A design that forwards the new page would allocate one cycle early.
- The exact edges of both excluded windows and the exact limit boundary, including the largest limit value. Off-by-one compares would flip the flag at these edges.
- Each gate applied alone while a qualifier is active. This shows that a dropped gate lets allocation through.

// File: rtl/wa_pkg.sv
package wa_pkg;
  // Fixed windows excluded from the limit-based path
  localparam logic [31:0] LEGACY_LO = 32'h000A_0000;
  localparam logic [31:0] LEGACY_HI = 32'h000F_FFFF;
  localparam logic [31:0] UPPER_LO  = 32'h00F0_0000;
  localparam logic [31:0] UPPER_HI  = 32'h00FF_FFFF;

  typedef struct packed {
    logic cache_off;
    logic page_nocache;
    logic inhibit;
  } wa_gate_t;

  typedef struct packed {
    logic page_hit;
    logic sector_hit;
    logic limit_ok;
  } wa_qual_t;
endpackage

// File: rtl/wa_page_tracker.sv
module wa_page_tracker #(
  parameter int PAGE_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_valid_i,
  input  logic [PAGE_W-1:0] fill_page_i,
  input  logic [PAGE_W-1:0] wr_page_i,
  output logic              page_hit_o
);
  logic              valid_q;
  logic [PAGE_W-1:0] page_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      page_q  <= '0;
    end else if (fill_valid_i) begin
      valid_q <= 1'b1;
      page_q  <= fill_page_i;
    end
  end

  // Old contents are compared; a same-cycle fill is not forwarded
  assign page_hit_o = valid_q && (page_q == wr_page_i);

  p_page_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid_i |=> (valid_q && page_q == $past(fill_page_i)));

  p_empty_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_q && !fill_valid_i) |=> !valid_q);
endmodule

// File: rtl/wa_limit_window.sv
module wa_limit_window
  import wa_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LIMIT_W    = 7,
  parameter int UNIT_SHIFT = 22
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               lim_en_i,
  input  logic [LIMIT_W-1:0] lim_val_i,
  input  logic               upper_en_i,
  output logic               limit_ok_o
);
  localparam int HI_W  = ADDR_W - UNIT_SHIFT;
  localparam int CMP_W = (HI_W > LIMIT_W) ? HI_W : LIMIT_W;

  logic [CMP_W-1:0] addr_units;
  logic [CMP_W-1:0] lim_units;
  logic below, in_legacy, in_upper;

  assign addr_units = CMP_W'(addr_i[ADDR_W-1:UNIT_SHIFT]);
  assign lim_units  = CMP_W'(lim_val_i);
  assign below      = addr_units < lim_units;
  assign in_legacy  = (addr_i >= ADDR_W'(LEGACY_LO)) && (addr_i <= ADDR_W'(LEGACY_HI));
  assign in_upper   = (addr_i >= ADDR_W'(UPPER_LO))  && (addr_i <= ADDR_W'(UPPER_HI));

  assign limit_ok_o = lim_en_i && (lim_val_i != '0) && below &&
                      !in_legacy && !(in_upper && !upper_en_i);

  p_zero_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_val_i == '0 || !lim_en_i) |-> !limit_ok_o);

  p_legacy_hole_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i[ADDR_W-1:20] == '0 && addr_i[19:17] >= 3'd5) |-> !limit_ok_o);

  p_upper_hole_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i[ADDR_W-1:20] == ADDR_W'(12'h00F) && !upper_en_i) |-> !limit_ok_o);
endmodule

// File: rtl/wa_decide_core.sv
module wa_decide_core
  import wa_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_i,
  input  wa_gate_t gate_i,
  input  wa_qual_t qual_i,
  output logic     alloc_o
);
  logic gates_open, any_qual;

  assign gates_open = !gate_i.cache_off && !gate_i.page_nocache && !gate_i.inhibit;
  assign any_qual   = qual_i.page_hit || qual_i.sector_hit || qual_i.limit_ok;
  assign alloc_o    = req_i && gates_open && any_qual;

  p_cache_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    gate_i.cache_off |-> !alloc_o);
  p_page_nocache_r2: assert property (@(posedge clk) disable iff (!rst_n)
    gate_i.page_nocache |-> !alloc_o);
  p_inhibit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gate_i.inhibit |-> !alloc_o);
  p_sector_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && qual_i.sector_hit && gate_i == '0) |-> alloc_o);
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |-> !alloc_o);
  p_noqual_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_i == '0) |-> !alloc_o);
endmodule

// File: rtl/wa_alloc_decide.sv
module wa_alloc_decide
  import wa_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int LIMIT_W    = 7,
  parameter int UNIT_SHIFT = 22
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_req,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic               sector_hit,
  input  logic               cache_off,
  input  logic               page_nocache,
  input  logic               cache_inhibit,
  input  logic               lim_en,
  input  logic [LIMIT_W-1:0] lim_val,
  input  logic               upper_en,
  input  logic               fill_valid,
  input  logic [ADDR_W-1:0]  fill_addr,
  output logic               alloc_o
);
  localparam int PAGE_W = ADDR_W - PAGE_SHIFT;

  wa_gate_t gates;
  wa_qual_t quals;
  logic     page_hit, limit_ok;

  assign gates = '{cache_off: cache_off, page_nocache: page_nocache, inhibit: cache_inhibit};

  wa_page_tracker #(.PAGE_W(PAGE_W)) u_page (
    .clk          (clk),
    .rst_n        (rst_n),
    .fill_valid_i (fill_valid),
    .fill_page_i  (fill_addr[ADDR_W-1:PAGE_SHIFT]),
    .wr_page_i    (wr_addr[ADDR_W-1:PAGE_SHIFT]),
    .page_hit_o   (page_hit)
  );

  wa_limit_window #(.ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W), .UNIT_SHIFT(UNIT_SHIFT)) u_limit (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_i     (wr_addr),
    .lim_en_i   (lim_en),
    .lim_val_i  (lim_val),
    .upper_en_i (upper_en),
    .limit_ok_o (limit_ok)
  );

  assign quals = '{page_hit: page_hit, sector_hit: sector_hit, limit_ok: limit_ok};

  wa_decide_core u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (wr_req),
    .gate_i  (gates),
    .qual_i  (quals),
    .alloc_o (alloc_o)
  );
endmodule

// File: tb/wa_alloc_decide_tb.sv
module wa_alloc_decide_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_req = 1'b0;
  logic [31:0] wr_addr = '0;
  logic        sector_hit = 1'b0;
  logic        cache_off = 1'b0;
  logic        page_nocache = 1'b0;
  logic        cache_inhibit = 1'b0;
  logic        lim_en = 1'b0;
  logic [6:0]  lim_val = '0;
  logic        upper_en = 1'b0;
  logic        fill_valid = 1'b0;
  logic [31:0] fill_addr = '0;
  logic        alloc_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wa_alloc_decide u_dut (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr),
    .sector_hit(sector_hit), .cache_off(cache_off), .page_nocache(page_nocache),
    .cache_inhibit(cache_inhibit), .lim_en(lim_en), .lim_val(lim_val),
    .upper_en(upper_en), .fill_valid(fill_valid), .fill_addr(fill_addr),
    .alloc_o(alloc_o)
  );

  task automatic chk(input logic exp, input string req, input string what);
    checks++;
    if (alloc_o !== exp) begin
      failures++;
      $display("FAIL %s %s: alloc_o=%b expected=%b", req, what, alloc_o, exp);
    end
  endtask

  task automatic write_at(input logic [31:0] a, input logic exp, input string req, input string what);
    @(negedge clk);
    wr_req = 1'b1; wr_addr = a;
    #1 chk(exp, req, what);
  endtask

  task automatic quiet();
    @(negedge clk);
    wr_req = 0; sector_hit = 0; cache_off = 0; page_nocache = 0; cache_inhibit = 0;
    lim_en = 0; lim_val = 0; upper_en = 0; fill_valid = 0;
  endtask

  task automatic t_reset_empty();
    write_at(32'h0000_0123, 1'b0, "R11", "page 0 after reset");
    write_at(32'h0000_0000, 1'b0, "R12", "no qualifier");
    quiet();
  endtask

  task automatic t_idle();
    @(negedge clk);
    wr_req = 0; sector_hit = 1; lim_en = 1; lim_val = 7'd4; wr_addr = 32'h0080_0000;
    #1 chk(1'b0, "R10", "qualifiers without request");
    quiet();
  endtask

  task automatic t_fill_same_cycle();
    @(negedge clk);
    fill_valid = 1; fill_addr = 32'h1234_5678;
    wr_req = 1; wr_addr = 32'h1234_5000;
    #1 chk(1'b0, "R5", "write in fill cycle");
    @(negedge clk);
    fill_valid = 0;
    #1 chk(1'b1, "R4", "write after fill");
    write_at(32'h1234_5FFF, 1'b1, "R4", "top of filled page");
    write_at(32'h1234_6000, 1'b0, "R4", "next page");
    @(negedge clk);
    fill_valid = 1; fill_addr = 32'h0000_0ABC; wr_addr = 32'h1234_5000;
    #1 chk(1'b1, "R5", "old page still matches in fill cycle");
    @(negedge clk);
    fill_valid = 0;
    #1 chk(1'b0, "R4", "old page replaced");
    write_at(32'h0000_0010, 1'b1, "R4", "new page 0 matches");
    quiet();
  endtask

  task automatic t_gates();
    @(negedge clk);
    sector_hit = 1; wr_req = 1; wr_addr = 32'h4000_0000;
    #1 chk(1'b1, "R6", "sector hit alone");
    cache_off = 1; #1 chk(1'b0, "R1", "cache off"); cache_off = 0;
    page_nocache = 1; #1 chk(1'b0, "R2", "page no-cache"); page_nocache = 0;
    cache_inhibit = 1; #1 chk(1'b0, "R3", "inhibit"); cache_inhibit = 0;
    sector_hit = 0; wr_addr = 32'h0000_0020;
    cache_off = 1; #1 chk(1'b0, "R1", "cache off with page hit"); cache_off = 0;
    #1 chk(1'b1, "R4", "page hit gates open");
    quiet();
  endtask

  task automatic t_limit();
    @(negedge clk);
    lim_en = 1; lim_val = 7'd4;
    write_at(32'h0080_0000, 1'b1, "R7", "8MB below 16MB limit");
    write_at(32'h0100_0000, 1'b0, "R7", "at limit");
    write_at(32'h0009_FFFF, 1'b1, "R8", "just below legacy hole");
    write_at(32'h000A_0000, 1'b0, "R8", "legacy hole start");
    write_at(32'h000F_FFFF, 1'b0, "R8", "legacy hole end");
    write_at(32'h0010_0000, 1'b1, "R8", "just above legacy hole");
    write_at(32'h00EF_FFFF, 1'b1, "R9", "just below upper hole");
    write_at(32'h00F0_0000, 1'b0, "R9", "upper hole start, disabled");
    write_at(32'h00FF_FFFF, 1'b0, "R9", "upper hole end, disabled");
    upper_en = 1;
    write_at(32'h00F0_0000, 1'b1, "R9", "upper hole start, enabled");
    write_at(32'h00FF_FFFF, 1'b1, "R9", "upper hole end, enabled");
    lim_val = 7'd0;
    write_at(32'h0000_1000, 1'b0, "R7", "zero limit");
    lim_val = 7'd4; lim_en = 0;
    write_at(32'h0080_0000, 1'b0, "R7", "path disabled");
    lim_en = 1; lim_val = 7'd127;
    write_at(32'h1FBF_FFFF, 1'b1, "R7", "max limit below");
    write_at(32'h1FC0_0000, 1'b0, "R7", "max limit at");
    quiet();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset_empty();
    t_idle();
    t_fill_same_cycle();
    t_gates();
    t_limit();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule